// File: doc/BRIEF.md
# Jittered-Clock Sampling XOR Decimator

This block turns the phase jitter between two nearly equal clocks into random bits. A free-running clock, `samp_in`, enters as a plain asynchronous data signal. The block samples it on every edge of its own clock `clk`. Two flip-flops in series capture the sample and let any metastability settle. The settled samples are then grouped into non-overlapping windows of K consecutive samples. Each window is folded by exclusive-OR into one output bit, `rnd_bit`, and `rnd_valid` marks that bit for one cycle.

The window length K comes from the runtime input `dec_factor`. The block latches K when a window opens, so a change only takes effect from the next window. The serial bits also feed a serial-to-parallel stage. That stage collects `WORD_W` bits least significant bit first and presents them on `word_out`, marked by a one-cycle `word_valid`.

The decimator runs a two-state machine. `ST_FIRST` takes the first sample of a window and latches K. `ST_REST` takes the remaining samples. The transitions are:
- `first_to_rest`: a window opens with K > 1.
- `rest_stay`: a sample that is not the last one.
- `rest_close`: the last sample, which emits the bit and returns to `ST_FIRST`.
- `first_single`: with K = 1, the bit is emitted while staying in `ST_FIRST`.

Top module: `jitter_xor_trng`

## Requirements
- R1: While `rst` is high at a clock edge, both synchronizer flops, the sample counter, the accumulator and the bit counter clear. After that edge, `rnd_valid`, `rnd_bit`, `word_valid` and `word_out` are all 0.
- R2: A value on `samp_in` at a rising edge reaches the decimator as a sample two edges later. The first two samples after reset are 0.
- R3: `rnd_bit` is the XOR of K consecutive samples. Windows neither overlap nor leave gaps, and the accumulator starts from 0 in each window.
- R4: `rnd_valid` is high for exactly one cycle per window, in the cycle after the edge that takes the window's last sample. `rnd_bit` holds its value between pulses.
- R5: K is taken from `dec_factor` at the edge that takes a window's first sample. A change during a window affects only later windows.
- R6: A `dec_factor` of 0 acts as 1. With K = 1, every sample is emitted and `rnd_valid` stays high continuously.
- R7: Serial bit number i (counting from 0) of each group of `WORD_W` lands at `word_out[i]`. `word_valid` pulses for one cycle, in the cycle after the `rnd_valid` of the group's last bit.
- R8: `word_out` holds its value between `word_valid` pulses.
- R9: After any reset, no `rnd_valid` appears until a full window of K samples has been taken. A partial window that a reset cuts off is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| samp_in | input | 1 | Jittered clock, sampled as asynchronous data |
| dec_factor | input | DEC_W | Samples per output bit (0 acts as 1) |
| rnd_bit | output | 1 | Serial random bit |
| rnd_valid | output | 1 | One-cycle strobe for `rnd_bit` |
| word_out | output | WORD_W | Assembled word, first bit in the LSB |
| word_valid | output | 1 | One-cycle strobe for `word_out` |

## Verification
On every cycle, the assertions check four things:
- the two-edge delay through the synchronizer;
- that the accumulator is empty whenever a window opens;
- that the sample counter stays below the latched K;
- that strobes appear only in the states and cycles where they belong.

Only the bench scenarios can show that the emitted bit equals the XOR of exactly the right K samples. They also show that a mid-window change of `dec_factor` waits for the next window, and that a reset drops a partial window. Finally, they confirm the bit order inside an assembled word, using sample patterns with known parity: constant ones over odd and even K, toggling input, and pseudo-random input.

// File: rtl/trng_pkg.sv
package trng_pkg;
    typedef enum logic [0:0] {
        ST_FIRST = 1'b0,
        ST_REST  = 1'b1
    } decim_state_t;
endpackage

// File: rtl/trng_sync2.sv
module trng_sync2 (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic stage1;
    logic [1:0] settle;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= 1'b0;
            q_sync <= 1'b0;
            settle <= 2'd0;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
            if (settle != 2'd2) settle <= settle + 2'd1;
        end
    end

    // R2
    sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (settle == 2'd2) |-> (q_sync == $past(d_async, 2)));
endmodule

// File: rtl/trng_xor_decim.sv
module trng_xor_decim
    import trng_pkg::*;
#(
    parameter int DEC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample,
    input  logic [DEC_W-1:0] dec_factor,
    output logic             bit_out,
    output logic             bit_valid
);
    localparam logic [DEC_W-1:0] ONE = DEC_W'(1);

    decim_state_t     state, state_nx;
    logic [DEC_W-1:0] cnt, k_lat;
    logic             acc;
    logic [DEC_W-1:0] k_eff;

    assign k_eff = (dec_factor == '0) ? ONE : dec_factor;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FIRST: if (k_eff != ONE) state_nx = ST_REST;
            ST_REST:  if (cnt == k_lat - ONE) state_nx = ST_FIRST;
            default:  state_nx = ST_FIRST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_FIRST;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            k_lat     <= ONE;
            acc       <= 1'b0;
            bit_out   <= 1'b0;
            bit_valid <= 1'b0;
        end else begin
            bit_valid <= 1'b0;
            unique case (state)
                ST_FIRST: begin
                    k_lat <= k_eff;
                    if (k_eff == ONE) begin
                        bit_out   <= sample;
                        bit_valid <= 1'b1;
                        acc       <= 1'b0;
                        cnt       <= '0;
                    end else begin
                        acc <= sample;
                        cnt <= ONE;
                    end
                end
                ST_REST: begin
                    if (cnt == k_lat - ONE) begin
                        bit_out   <= acc ^ sample;
                        bit_valid <= 1'b1;
                        acc       <= 1'b0;
                        cnt       <= '0;
                    end else begin
                        acc <= acc ^ sample;
                        cnt <= cnt + ONE;
                    end
                end
                default: begin
                    acc <= 1'b0;
                    cnt <= '0;
                end
            endcase
        end
    end

    // R3
    acc_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FIRST) |-> (acc == 1'b0));
    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_REST) |-> (cnt < k_lat && cnt != '0));
    // R4
    no_mid_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_REST) |-> !bit_valid);
endmodule

// File: rtl/trng_deser.sv
module trng_deser #(
    parameter int WORD_W = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_in,
    input  logic              bit_valid,
    output logic [WORD_W-1:0] word,
    output logic              word_valid
);
    localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [WORD_W-1:0] shreg, shreg_nx;
    logic [CNT_W-1:0]  bcnt;

    generate
        if (WORD_W > 1) begin : g_wide
            assign shreg_nx = {bit_in, shreg[WORD_W-1:1]};
        end else begin : g_single
            assign shreg_nx = bit_in;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg      <= '0;
            word       <= '0;
            bcnt       <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            if (bit_valid) begin
                shreg <= shreg_nx;
                if (bcnt == LAST) begin
                    word       <= shreg_nx;
                    word_valid <= 1'b1;
                    bcnt       <= '0;
                end else begin
                    bcnt <= bcnt + CNT_W'(1);
                end
            end
        end
    end

    // R7
    word_after_bit_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> $past(bit_valid));
    // R8
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !word_valid |-> $stable(word));
endmodule

// File: rtl/jitter_xor_trng.sv
module jitter_xor_trng #(
    parameter int DEC_W  = 16,
    parameter int WORD_W = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              samp_in,
    input  logic [DEC_W-1:0]  dec_factor,
    output logic              rnd_bit,
    output logic              rnd_valid,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid
);
    logic settled;

    trng_sync2 u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (samp_in),
        .q_sync  (settled)
    );

    trng_xor_decim #(.DEC_W(DEC_W)) u_decim (
        .clk        (clk),
        .rst        (rst),
        .sample     (settled),
        .dec_factor (dec_factor),
        .bit_out    (rnd_bit),
        .bit_valid  (rnd_valid)
    );

    trng_deser #(.WORD_W(WORD_W)) u_deser (
        .clk        (clk),
        .rst        (rst),
        .bit_in     (rnd_bit),
        .bit_valid  (rnd_valid),
        .word       (word_out),
        .word_valid (word_valid)
    );

    // R4
    bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rnd_valid |-> $stable(rnd_bit));
endmodule

// File: tb/jitter_xor_trng_tb.sv
module jitter_xor_trng_tb;
    localparam int DEC_W  = 16;
    localparam int WORD_W = 128;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              samp_in = 1'b0;
    logic [DEC_W-1:0]  dec_factor = 16'd1;
    logic              rnd_bit, rnd_valid, word_valid;
    logic [WORD_W-1:0] word_out;

    jitter_xor_trng #(.DEC_W(DEC_W), .WORD_W(WORD_W)) u_dut (
        .clk(clk), .rst(rst), .samp_in(samp_in), .dec_factor(dec_factor),
        .rnd_bit(rnd_bit), .rnd_valid(rnd_valid),
        .word_out(word_out), .word_valid(word_valid)
    );

    always #10 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    string tag = "R1";

    // behavioural reference
    bit                pipe[$];
    int                m_cnt, m_k, m_wcnt;
    bit                m_acc, exp_v, exp_bit, exp_wv;
    logic [WORD_W-1:0] m_wbits, exp_word;

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            pipe = {1'b0, 1'b0};
            m_cnt = 0; m_k = 1; m_acc = 0; m_wcnt = 0;
            exp_v = 0; exp_bit = 0; exp_wv = 0;
            m_wbits = '0; exp_word = '0;
        end else begin
            bit s;
            s = pipe.pop_front();
            pipe.push_back(samp_in);
            if (m_cnt == 0) m_k = (dec_factor == 0) ? 1 : int'(dec_factor);
            m_acc ^= s;
            m_cnt++;
            exp_wv = 0;
            if (exp_v) begin
                m_wbits[m_wcnt] = exp_bit;
                m_wcnt++;
                if (m_wcnt == WORD_W) begin
                    exp_wv = 1; exp_word = m_wbits; m_wcnt = 0;
                end
            end
            exp_v = (m_cnt == m_k);
            if (exp_v) begin
                exp_bit = m_acc; m_acc = 0; m_cnt = 0;
            end
        end
    end

    always @(negedge clk) begin
        n_cmp++;
        if (rnd_valid !== exp_v) begin
            n_bad++;
            $display("FAIL %s/R4 rnd_valid act=%0b exp=%0b", tag, rnd_valid, exp_v);
        end
        n_cmp++;
        if (exp_v && rnd_bit !== exp_bit) begin
            n_bad++;
            $display("FAIL %s/R3 rnd_bit act=%0b exp=%0b", tag, rnd_bit, exp_bit);
        end
        n_cmp++;
        if (word_valid !== exp_wv) begin
            n_bad++;
            $display("FAIL %s/R7 word_valid act=%0b exp=%0b", tag, word_valid, exp_wv);
        end
        n_cmp++;
        if (word_out !== exp_word) begin
            n_bad++;
            $display("FAIL %s/R8 word_out act=%h exp=%h", tag, word_out, exp_word);
        end
    end

    logic [15:0] lfsr = 16'hACE1;

    // mode 0 random, 1 const one, 2 toggle, 3 const zero
    task automatic run(input int n, input int mode);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (mode)
                0: samp_in = lfsr[0];
                1: samp_in = 1'b1;
                2: samp_in = ~samp_in;
                default: samp_in = 1'b0;
            endcase
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        tag = "R1";
        repeat (3) @(negedge clk);
        n_cmp++;
        if (rnd_valid !== 1'b0 || word_valid !== 1'b0 || word_out !== '0 || rnd_bit !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset outputs act=%0b%0b exp=00", rnd_valid, word_valid);
        end
        rst = 1'b0;
        tag = "R2"; dec_factor = 16'd3; run(30, 1);
        tag = "R6"; dec_factor = 16'd1; run(300, 0);
        tag = "R6"; dec_factor = 16'd0; run(150, 0);
        tag = "R3"; dec_factor = 16'd5; run(60, 1);
        tag = "R3"; dec_factor = 16'd4; run(60, 1);
        tag = "R3"; dec_factor = 16'd3; run(60, 2);
        tag = "R5"; dec_factor = 16'd7; run(4, 0);
        dec_factor = 16'd2; run(40, 0);
        dec_factor = 16'd9; run(3, 1);
        dec_factor = 16'd1; run(30, 1);
        tag = "R7"; dec_factor = 16'd2; run(600, 0);
        tag = "R9"; dec_factor = 16'd6; run(4, 1);
        do_reset();
        run(20, 3);
        tag = "R3"; dec_factor = 16'd209; run(700, 0);
        tag = "R7"; dec_factor = 16'd1; run(300, 2);
        summary();
    end

    initial begin
        wait (cycles > 150000);
        n_bad++;
        $display("FAIL watchdog R1 act=%0d exp=<150000", cycles);
        summary();
    end
endmodule